// File: doc/BRIEF.md
# Integer Execute Stage with Reverse Subtract

This block is the arithmetic and logic execute stage of a small 32-bit integer pipeline. Each request carries a 4-bit function code, a first operand from the register file, and a second operand that is either a register value or a 13-bit immediate. The immediate is zero-extended or sign-extended, as the request selects. The stage computes shifts, bitwise logic, addition, subtraction and reverse subtraction (each with a carry-consuming form), and a load of a 19-bit immediate into the upper result bits.

The stage keeps the condition flags (zero, negative, overflow, carry) in its own register. A per-request set-flags bit decides whether that register is written. The carry-consuming operations read the stored carry flag. Result, flags and a valid strobe are registered, so a result appears one clock after its request. Function codes outside the defined set raise an illegal-operation indication and leave the flags untouched.

Top module: `xu_exec`

## Requirements
- R1: While reset is low and on the first cycle after it, `res_valid`, `illegal`, `result` and `cc_flags` are all zero.
- R2: `res_valid` is high in exactly those cycles that follow a cycle with `req_valid` high. `result` and `illegal` change only after a request.
- R3: With `use_imm`=1 the second operand is `imm13`, sign-extended when `imm_signed`=1 and zero-extended when it is 0. With `use_imm`=0 the second operand is `rs2_val`.
- R4: Function 1 shifts the first operand left logically, 2 shifts it right arithmetically and 3 shifts it right logically. Each uses only bits 4:0 of the second operand as the amount.
- R5: Function 5 gives the AND of the operands, 6 the OR and 7 the XOR.
- R6: Function 8 gives s1 + s2, and function 9 gives s1 + s2 + C, where C is the stored carry flag.
- R7: Function 12 gives s1 + NOT(s2) + 1, and function 13 gives s1 + NOT(s2) + C.
- R8: Function 14 gives s2 − s1, and function 15 gives s2 + NOT(s1) + C.
- R9: Function 4 places `imm19` in result bits 31:13, with bits 12:0 zero.
- R10: Functions 0, 10 and 11 drive `illegal` high one cycle later with `result` zero, and they never change `cc_flags`.
- R11: `cc_flags` is written only by a legal request with `set_cc`=1. Every other cycle leaves it unchanged.
- R12: `cc_flags` is {Z,N,V,C} in bits 3..0. Z is set when the result is zero and N equals result bit 31. For functions 8, 9 and 12–15, C is the carry out of the 32-bit sum and V is signed overflow. For functions 1–7, V and C are written as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| func | input | 4 | Function code |
| set_cc | input | 1 | Write flags with this request |
| use_imm | input | 1 | Second operand from immediate |
| imm_signed | input | 1 | Sign-extend the 13-bit immediate |
| rs1_val | input | 32 | First operand |
| rs2_val | input | 32 | Register second operand |
| imm13 | input | 13 | Short immediate |
| imm19 | input | 19 | Load-high immediate |
| res_valid | output | 1 | Result valid, one cycle after request |
| result | output | 32 | Registered result |
| illegal | output | 1 | Last request had an undefined code |
| cc_flags | output | 4 | Flag register {Z,N,V,C} |

## Verification
Two things can land on the same edge: a carry-consuming operation reading C, and the flag update from the request just before it. The bench provokes this with back-to-back requests, where an add or subtract with `set_cc` is followed at once by function 9, 13 or 15. The result must use the carry written by the previous request and not an older one. A bench model tracks its own flag copy, updated only by legal requests with `set_cc` set, and judges each result against it. Randomly mixed illegal codes and cleared `set_cc` bits check that the carry chain survives requests that must not touch the flags.

// File: rtl/xu_pkg.sv
// Package: shared function codes and the flag record for the execute stage.
// Assumes the function codes are decoded only inside the arithmetic/logic group.
package xu_pkg;

    typedef enum logic [3:0] {
        FN_BAD0  = 4'd0,
        FN_SLL   = 4'd1,
        FN_SRA   = 4'd2,
        FN_SRL   = 4'd3,
        FN_LDHI  = 4'd4,
        FN_AND   = 4'd5,
        FN_OR    = 4'd6,
        FN_XOR   = 4'd7,
        FN_ADD   = 4'd8,
        FN_ADDC  = 4'd9,
        FN_BAD10 = 4'd10,
        FN_BAD11 = 4'd11,
        FN_SUB   = 4'd12,
        FN_SUBC  = 4'd13,
        FN_RSUB  = 4'd14,
        FN_RSUBC = 4'd15
    } xu_func_e;

    typedef struct packed {
        logic z;
        logic n;
        logic v;
        logic c;
    } xu_flags_t;

endpackage

// File: rtl/xu_opnd.sv
// Module: second-operand select. Picks the register value or the short
// immediate, extended with sign or zeros. Purely combinational.
module xu_opnd #(
    parameter int W    = 32,
    parameter int IMMW = 13
) (
    input  logic            use_imm,
    input  logic            imm_signed,
    input  logic [W-1:0]    reg_val,
    input  logic [IMMW-1:0] imm,
    output logic [W-1:0]    opnd
);
    localparam int EXTW = W - IMMW;

    logic [EXTW-1:0] ext_bits;

    // Extension bits: copies of the immediate sign, or zeros.
    always_comb begin
        ext_bits = imm_signed ? {EXTW{imm[IMMW-1]}} : '0;
    end

    // Final operand choice.
    always_comb begin
        opnd = use_imm ? {ext_bits, imm} : reg_val;
    end
endmodule

// File: rtl/xu_adder.sv
// Module: shared adder for add, subtract and reverse subtract, with and
// without carry-in. Assumes func is one of the arithmetic codes when its
// outputs are used; for other codes the outputs are don't-care.
module xu_adder
    import xu_pkg::*;
#(
    parameter int W = 32
) (
    input  xu_func_e     func,
    input  logic [W-1:0] s1,
    input  logic [W-1:0] s2,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout,
    output logic         ovf
);
    logic [W-1:0] x;
    logic [W-1:0] y;
    logic         ci;
    logic [W:0]   wide;

    // Route operands: inversion and operand swap for the subtract forms.
    always_comb begin
        x  = s1;
        y  = s2;
        ci = 1'b0;
        unique case (func)
            FN_ADDC:  ci = cin;
            FN_SUB:   begin y = ~s2; ci = 1'b1; end
            FN_SUBC:  begin y = ~s2; ci = cin;  end
            FN_RSUB:  begin x = s2; y = ~s1; ci = 1'b1; end
            FN_RSUBC: begin x = s2; y = ~s1; ci = cin;  end
            default:  ci = 1'b0;
        endcase
    end

    // One carry-propagate sum, carry out and signed overflow.
    always_comb begin
        wide = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, ci};
        sum  = wide[W-1:0];
        cout = wide[W];
        ovf  = (x[W-1] == y[W-1]) && (sum[W-1] != x[W-1]);
    end
endmodule

// File: rtl/xu_logic.sv
// Module: shifts, bitwise logic and load-high. The shift amount is the low
// log2(W) bits of the second operand. Assumes W = HIW + (low zero bits).
module xu_logic
    import xu_pkg::*;
#(
    parameter int W   = 32,
    parameter int HIW = 19
) (
    input  xu_func_e       func,
    input  logic [W-1:0]   s1,
    input  logic [W-1:0]   s2,
    input  logic [HIW-1:0] imm_hi,
    output logic [W-1:0]   res
);
    localparam int SHW = $clog2(W);
    localparam int LOW = W - HIW;

    logic [SHW-1:0] amt;

    // Shift amount from the low operand bits only.
    always_comb begin
        amt = s2[SHW-1:0];
    end

    // Function select for the non-adder operations.
    always_comb begin
        unique case (func)
            FN_SLL:  res = s1 << amt;
            FN_SRA:  res = W'($signed(s1) >>> amt);
            FN_SRL:  res = s1 >> amt;
            FN_LDHI: res = {imm_hi, {LOW{1'b0}}};
            FN_AND:  res = s1 & s2;
            FN_OR:   res = s1 | s2;
            FN_XOR:  res = s1 ^ s2;
            default: res = '0;
        endcase
    end
endmodule

// File: rtl/xu_exec.sv
// Module: execute stage top. Decodes the function code, merges the adder and
// logic paths, and registers result, illegal flag, valid and the flag
// register. Assumes one request per cycle at most; the carry-in of carry
// forms is the stored C flag as it stands before this request's update.
module xu_exec
    import xu_pkg::*;
#(
    parameter int W    = 32,
    parameter int IMMW = 13,
    parameter int HIW  = 19
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic [3:0]      func,
    input  logic            set_cc,
    input  logic            use_imm,
    input  logic            imm_signed,
    input  logic [W-1:0]    rs1_val,
    input  logic [W-1:0]    rs2_val,
    input  logic [IMMW-1:0] imm13,
    input  logic [HIW-1:0]  imm19,
    output logic            res_valid,
    output logic [W-1:0]    result,
    output logic            illegal,
    output logic [3:0]      cc_flags
);
    xu_func_e     fn;
    xu_flags_t    flags_q;
    xu_flags_t    flags_d;
    logic [W-1:0] opnd2;
    logic [W-1:0] add_sum;
    logic         add_cout;
    logic         add_ovf;
    logic [W-1:0] lg_res;
    logic [W-1:0] nxt_res;
    logic         legal;
    logic         is_arith;

    // Cast the raw code to the package enum.
    always_comb begin
        fn = xu_func_e'(func);
    end

    xu_opnd #(.W(W), .IMMW(IMMW)) u_opnd (
        .use_imm    (use_imm),
        .imm_signed (imm_signed),
        .reg_val    (rs2_val),
        .imm        (imm13),
        .opnd       (opnd2)
    );

    xu_adder #(.W(W)) u_adder (
        .func (fn),
        .s1   (rs1_val),
        .s2   (opnd2),
        .cin  (flags_q.c),
        .sum  (add_sum),
        .cout (add_cout),
        .ovf  (add_ovf)
    );

    xu_logic #(.W(W), .HIW(HIW)) u_logic (
        .func   (fn),
        .s1     (rs1_val),
        .s2     (opnd2),
        .imm_hi (imm19),
        .res    (lg_res)
    );

    // Classify the code: undefined codes and adder-group codes.
    always_comb begin
        legal    = !(fn inside {FN_BAD0, FN_BAD10, FN_BAD11});
        is_arith = fn inside {FN_ADD, FN_ADDC, FN_SUB, FN_SUBC, FN_RSUB, FN_RSUBC};
    end

    // Merge the datapaths and form the candidate flags.
    always_comb begin
        nxt_res   = is_arith ? add_sum : lg_res;
        flags_d.z = (nxt_res == '0);
        flags_d.n = nxt_res[W-1];
        flags_d.v = is_arith & add_ovf;
        flags_d.c = is_arith & add_cout;
    end

    // Output and flag registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            result    <= '0;
            illegal   <= 1'b0;
            flags_q   <= '0;
        end else begin
            res_valid <= req_valid;
            if (req_valid) begin
                illegal <= ~legal;
                result  <= legal ? nxt_res : '0;
                if (legal && set_cc) begin
                    flags_q <= flags_d;
                end
            end
        end
    end

    // Drive the packed flag port.
    always_comb begin
        cc_flags = flags_q;
    end
endmodule

// File: rtl/xu_exec_chk.sv
// Module: property checker for the execute stage, bound to every instance
// of the top. Observes ports only.
module xu_exec_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         req_valid,
    input logic [3:0]   func,
    input logic         set_cc,
    input logic         res_valid,
    input logic [W-1:0] result,
    input logic         illegal,
    input logic [3:0]   cc_flags
);
    // R2
    valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> res_valid);

    // R2
    valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !res_valid && $stable(result) && $stable(illegal));

    // R11
    flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && set_cc) |=> $stable(cc_flags));

    // R10
    bad_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && (func == 4'd0 || func == 4'd10 || func == 4'd11)
        |=> illegal && result == '0 && $stable(cc_flags));

    // R9
    ldhi_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && func == 4'd4 |=> result[12:0] == 13'd0 && !illegal);

    // R12
    logic_vc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && set_cc && func >= 4'd1 && func <= 4'd7
        |=> cc_flags[1:0] == 2'b00);

    // R12
    zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && set_cc && func != 4'd0 && func != 4'd10 && func != 4'd11
        |=> cc_flags[3] == (result == '0) && cc_flags[2] == result[W-1]);
endmodule

bind xu_exec xu_exec_chk #(.W(W)) u_exec_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .func      (func),
    .set_cc    (set_cc),
    .res_valid (res_valid),
    .result    (result),
    .illegal   (illegal),
    .cc_flags  (cc_flags)
);

// File: tb/xu_exec_test.sv
module xu_exec_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [3:0]  func = '0;
    logic        set_cc = 1'b0;
    logic        use_imm = 1'b0;
    logic        imm_signed = 1'b0;
    logic [31:0] rs1_val = '0;
    logic [31:0] rs2_val = '0;
    logic [12:0] imm13 = '0;
    logic [18:0] imm19 = '0;
    logic        res_valid;
    logic [31:0] result;
    logic        illegal;
    logic [3:0]  cc_flags;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    logic [3:0]  exp_flags = 4'h0;
    logic [31:0] exp_res   = '0;

    always #10 clk = ~clk;

    xu_exec uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .func(func),
        .set_cc(set_cc), .use_imm(use_imm), .imm_signed(imm_signed),
        .rs1_val(rs1_val), .rs2_val(rs2_val), .imm13(imm13), .imm19(imm19),
        .res_valid(res_valid), .result(result), .illegal(illegal),
        .cc_flags(cc_flags)
    );

    // Requirement tag for a function code.
    function automatic string tag_of(int f);
        case (f)
            1, 2, 3:      return "R4";
            4:            return "R9";
            5, 6, 7:      return "R5";
            8, 9:         return "R6";
            12, 13:       return "R7";
            14, 15:       return "R8";
            default:      return "R10";
        endcase
    endfunction

    // Reference model: returns {illegal, Z, N, V, C, result}.
    function automatic logic [36:0] model(int f, logic [31:0] s1, logic [31:0] s2,
                                          logic [18:0] hi, logic cin);
        longint sa, sb, ua, ub, ex;
        logic [31:0] r;
        logic v, c;
        bit ar;
        sa = longint'($signed(s1)); sb = longint'($signed(s2));
        ua = longint'(s1); ub = longint'(s2);
        v = 0; c = 0; ar = 0; r = '0; ex = 0;
        case (f)
            1: r = s1 << s2[4:0];
            2: r = 32'($signed(s1) >>> s2[4:0]);
            3: r = s1 >> s2[4:0];
            4: r = {hi, 13'd0};
            5: r = s1 & s2;
            6: r = s1 | s2;
            7: r = s1 ^ s2;
            8, 9: begin
                ar = 1;
                ex = sa + sb + ((f == 9) ? longint'(cin) : 0);
                c  = (ua + ub + ((f == 9) ? longint'(cin) : 0)) > 64'hFFFF_FFFF;
            end
            12, 13: begin
                ar = 1;
                ex = sa - sb - ((f == 13) ? longint'(!cin) : 0);
                c  = ua >= ub + ((f == 13) ? longint'(!cin) : 0);
            end
            14, 15: begin
                ar = 1;
                ex = sb - sa - ((f == 15) ? longint'(!cin) : 0);
                c  = ub >= ua + ((f == 15) ? longint'(!cin) : 0);
            end
            default: return {1'b1, 4'h0, 32'h0};
        endcase
        if (ar) begin
            r = ex[31:0];
            v = (ex > 64'sd2147483647) || (ex < -64'sd2147483648);
        end
        return {1'b0, (r == 32'h0), r[31], v, c, r};
    endfunction

    task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Issue one request at a falling edge; check at the next falling edge.
    task automatic op(int f, logic [31:0] a, logic [31:0] b, bit ui, bit sg,
                      logic [12:0] im, logic [18:0] hi, bit scc, string req);
        logic [31:0] s2;
        logic [36:0] m;
        s2 = ui ? (sg ? {{19{im[12]}}, im} : {19'd0, im}) : b;
        m  = model(f, a, s2, hi, exp_flags[0]);
        req_valid = 1; func = 4'(f); set_cc = scc; use_imm = ui; imm_signed = sg;
        rs1_val = a; rs2_val = b; imm13 = im; imm19 = hi;
        @(negedge clk);
        if (m[36] == 1'b0 && scc) exp_flags = m[35:32];
        exp_res = m[31:0];
        check(req, "result", {31'd0, illegal, result}, {31'd0, m[36], m[31:0]});
        check("R11", "flags", {60'd0, cc_flags}, {60'd0, exp_flags});
        check("R2", "valid", {63'd0, res_valid}, 64'd1);
    endtask

    task automatic idle(int n);
        req_valid = 0;
        repeat (n) begin
            func = 4'($urandom_range(15)); set_cc = 1; rs1_val = $urandom();
            @(negedge clk);
            check("R2", "idle valid/result", {31'd0, res_valid, result}, {31'd0, 1'b0, exp_res});
            check("R11", "idle flags", {60'd0, cc_flags}, {60'd0, exp_flags});
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        check("R1", "reset outputs", {27'd0, res_valid, illegal, cc_flags, 32'd0} | {32'd0, result},
              64'd0);
        rst_n = 1;
        @(negedge clk);
        check("R1", "post-reset outputs", {27'd0, res_valid, illegal, cc_flags, result}, 64'd0);

        // Directed corners.
        op(1, 32'h0000_0001, 32'd33, 0, 0, 0, 0, 1, "R4");          // amount masked to 1
        op(2, 32'h8000_0010, 32'd4, 0, 0, 0, 0, 1, "R4");
        op(3, 32'h8000_0010, 32'd4, 0, 0, 0, 0, 1, "R4");
        op(4, 32'hFFFF_FFFF, 0, 0, 0, 13'h1FFF, 19'h5_A5A5, 1, "R9");
        op(5, 32'hF0F0_1234, 0, 1, 1, 13'h1F0F, 0, 1, "R3");        // signed immediate
        op(6, 32'h0000_0000, 0, 1, 0, 13'h1000, 0, 1, "R3");        // zero-extended
        op(8, 32'h7FFF_FFFF, 32'd1, 0, 0, 0, 0, 1, "R6");           // signed overflow
        op(8, 32'hFFFF_FFFF, 32'd1, 0, 0, 0, 0, 1, "R6");           // carry, zero
        op(9, 32'd5, 32'd6, 0, 0, 0, 0, 1, "R6");                   // uses C=1
        op(12, 32'd9, 32'd9, 0, 0, 0, 0, 1, "R7");                  // zero, no borrow
        op(13, 32'd9, 32'd9, 0, 0, 0, 0, 1, "R7");
        op(12, 32'd1, 32'd2, 0, 0, 0, 0, 1, "R7");                  // borrow -> C=0
        op(13, 32'd10, 32'd3, 0, 0, 0, 0, 1, "R7");                 // C=0 consumed
        op(14, 32'd3, 32'd10, 0, 0, 0, 0, 1, "R8");
        op(15, 32'd3, 32'd10, 0, 0, 0, 0, 0, "R8");                 // C=1, no write
        op(14, 32'h8000_0000, 32'd0, 0, 0, 0, 0, 1, "R8");          // overflow
        op(0, 32'd1, 32'd1, 0, 0, 0, 0, 1, "R10");
        op(10, 32'd1, 32'd1, 0, 0, 0, 0, 1, "R10");
        op(11, 32'd1, 32'd1, 0, 0, 0, 0, 1, "R10");
        op(7, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 0, 0, 0, 1, "R12");  // V,C cleared, Z set
        op(8, 32'h1234, 32'h1, 0, 0, 0, 0, 0, "R11");               // no flag write
        idle(3);

        // Constrained random, back-to-back with occasional gaps.
        for (int i = 0; i < 2000; i++) begin
            int f;
            f = $urandom_range(15);
            op(f, $urandom(), ($urandom_range(3) == 0) ? 32'($urandom_range(40)) : $urandom(),
               $urandom_range(1) == 1, $urandom_range(1) == 1, 13'($urandom()),
               19'($urandom()), $urandom_range(3) != 0, tag_of(f));
            if ($urandom_range(15) == 0) idle(1);
        end

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule